// File: doc/BRIEF.md
# GPIO Bank with Per-Line Interrupt Sources

This block manages a bank of general-purpose lines. Each line can be an input or an output. Every input passes through a two-flop synchroniser. It is then XORed with a per-line inversion bit to give the line's logical value. Software reads that logical value, and the interrupt logic uses the same value.

Each line has two interrupt sources:
- A level source, which follows the logical value gated by a level enable.
- An edge source, which is a sticky flag set by a low-to-high change of the logical value and gated by an edge enable.

The enabled sources are ORed over groups of adjacent lines, and each group drives one summary interrupt output. To catch falling edges, software sets the inversion bit. To catch both edges, software toggles the inversion bit after each event.

A small synchronous register bus gives access to the bank. A write completes on the clock edge where `bus_sel` and `bus_wr` are high. A read returns its data on `bus_rdata` one cycle later, and the value is held until the next read.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction register reads all ones (all lines inputs). The output, inversion, edge-flag, edge-enable and level-enable registers read zero. `pin_oe` is zero and `irq_group` is zero.
- R2: The logical value of line i is its input, delayed by two clock edges of synchronisation, XORed with inversion bit i. Setting the inversion bit turns a falling pin edge into a rising logical edge.
- R3: A read at byte offset 0x0C returns, per bit, the logical value when direction bit i is 1 (input) and output register bit i when it is 0 (output). Writes to this offset have no effect.
- R4: `pin_out` equals the output register, and `pin_oe` bit i is 1 exactly when direction bit i is 0.
- R5: The level source of a line is its logical value ANDed with its level-enable bit, and it is not stored. A level interrupt appears two clock edges after the pin rises and is gone two edges after it falls.
- R6: A 0-to-1 change of a line's logical value sets its edge flag on the next clock edge, three edges after the pin change. The flag stays set when the line returns low, and it is recorded even while its edge enable is 0.
- R7: Writing the edge-flag register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R8: When a new edge and a clearing write hit the same bit on the same clock edge, the bit ends up 1.
- R9: `irq_group[g]` is the OR, over lines 8g to 8g+7, of (logical value AND level enable) OR (edge flag AND edge enable).
- R10: Register byte offsets are: 0x00 output, 0x04 direction, 0x08 inversion, 0x0C logical value (read-only), 0x10 edge flags, 0x14 edge enable, 0x18 level enable. Bit i of each register belongs to line i. Read data appears on `bus_rdata` one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Asynchronous line levels |
| pin_out | output | 32 | Output register value driven to the lines |
| pin_oe | output | 32 | Per-line output enable (1 = drive) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_group | output | 4 | Summary interrupt per group of eight lines |

## Verification
Each result is checked at the edge where it is due:
- A level interrupt is checked one edge after a pin change (still quiet) and again at the second edge, when it must be present.
- An edge-driven interrupt is checked at the second edge (still quiet) and at the third edge.
- Read data is compared one cycle after the read. A monitor pops the expected value from a queue at the falling edge that follows the capturing rising edge.

For the set-versus-clear case, the clearing write is placed on the exact edge at which the synchronised rise is recorded.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFF_OUT   = 5'h00,
        OFF_DIR   = 5'h04,
        OFF_POL   = 5'h08,
        OFF_DIN   = 5'h0C,
        OFF_CAUSE = 5'h10,
        OFF_EMASK = 5'h14,
        OFF_LMASK = 5'h18
    } reg_off_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_d, meta_q, stab_d, stab_q;

    always_comb begin
        meta_d = d;
        stab_d = meta_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pin_sync,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      out_r,
    output logic [W-1:0]      dir_r,
    output logic [W-1:0]      pol_r,
    output logic [W-1:0]      din,
    output logic [W-1:0]      cause_r,
    output logic [W-1:0]      emask_r,
    output logic [W-1:0]      lmask_r
);
    typedef struct packed {
        logic [W-1:0] out;
        logic [W-1:0] dir;
        logic [W-1:0] pol;
        logic [W-1:0] cause;
        logic [W-1:0] emask;
        logic [W-1:0] lmask;
        logic [W-1:0] din_prev;
        logic [W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;
    logic [W-1:0] din_c, rise_c, keep_c;

    always_comb begin
        st_d   = st_q;
        din_c  = pin_sync ^ st_q.pol;
        rise_c = din_c & ~st_q.din_prev;
        keep_c = '1;
        st_d.din_prev = din_c;

        if (bus_sel && bus_wr) begin
            case (bus_addr)
                OFF_OUT:   st_d.out   = bus_wdata;
                OFF_DIR:   st_d.dir   = bus_wdata;
                OFF_POL:   st_d.pol   = bus_wdata;
                OFF_CAUSE: keep_c     = bus_wdata;
                OFF_EMASK: st_d.emask = bus_wdata;
                OFF_LMASK: st_d.lmask = bus_wdata;
                default: ;
            endcase
        end

        // a fresh edge outranks a same-cycle clear
        st_d.cause = (st_q.cause & keep_c) | rise_c;

        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFF_OUT:   st_d.rdata = st_q.out;
                OFF_DIR:   st_d.rdata = st_q.dir;
                OFF_POL:   st_d.rdata = st_q.pol;
                OFF_DIN:   st_d.rdata = (din_c & st_q.dir) | (st_q.out & ~st_q.dir);
                OFF_CAUSE: st_d.rdata = st_q.cause;
                OFF_EMASK: st_d.rdata = st_q.emask;
                OFF_LMASK: st_d.rdata = st_q.lmask;
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.dir <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign out_r     = st_q.out;
    assign dir_r     = st_q.dir;
    assign pol_r     = st_q.pol;
    assign din       = din_c;
    assign cause_r   = st_q.cause;
    assign emask_r   = st_q.emask;
    assign lmask_r   = st_q.lmask;
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int unsigned W     = 32,
    parameter int unsigned GROUP = 8,
    localparam int unsigned NGRP = W / GROUP
) (
    input  logic [W-1:0]    din,
    input  logic [W-1:0]    lmask,
    input  logic [W-1:0]    cause,
    input  logic [W-1:0]    emask,
    output logic [NGRP-1:0] irq
);
    logic [W-1:0] src;

    assign src = (din & lmask) | (cause & emask);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign irq[g] = |src[g*GROUP +: GROUP];
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned GROUP    = 8,
    localparam int unsigned NGRP    = NUM_PINS / GROUP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic [NGRP-1:0]     irq_group
);
    logic [NUM_PINS-1:0] pin_sync, out_r, dir_r, pol_r, din, cause_r, emask_r, lmask_r;

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_regs #(.W(NUM_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .out_r(out_r), .dir_r(dir_r), .pol_r(pol_r), .din(din),
        .cause_r(cause_r), .emask_r(emask_r), .lmask_r(lmask_r)
    );

    gpio_irq_merge #(.W(NUM_PINS), .GROUP(GROUP)) u_merge (
        .din(din), .lmask(lmask_r), .cause(cause_r), .emask(emask_r), .irq(irq_group)
    );

    assign pin_out = out_r;
    assign pin_oe  = ~dir_r;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned GROUP    = 8,
    localparam int unsigned NGRP    = NUM_PINS / GROUP
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_rdata,
    input logic [NUM_PINS-1:0] pol,
    input logic [NUM_PINS-1:0] din,
    input logic [NUM_PINS-1:0] cause,
    input logic [NUM_PINS-1:0] emask,
    input logic [NUM_PINS-1:0] lmask,
    input logic [NGRP-1:0]     irq_group
);
    logic [NUM_PINS-1:0] din_last;
    logic [NGRP-1:0]     want_irq;
    logic                clr_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) din_last <= '0;
        else        din_last <= din;
    end

    always_comb begin
        for (int g = 0; g < int'(NGRP); g++) begin
            want_irq[g] = |(((din & lmask) | (cause & emask)) >> (g * GROUP) & {{(NUM_PINS-GROUP){1'b0}}, {GROUP{1'b1}}});
        end
    end

    assign clr_wr = bus_sel && bus_wr && (bus_addr == OFF_CAUSE);

    // R6
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (($past(cause) & ~cause) == '0));

    // R8
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((din & ~din_last) != '0) |=> ((cause & $past(din & ~din_last)) == $past(din & ~din_last)));

    // R9
    group_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_group == want_irq);

    // R5
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((din & lmask) | (cause & emask)) == '0) |-> (irq_group == '0));

    // R10
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFF_POL) |=> (bus_rdata == $past(pol)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS), .GROUP(GROUP)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pol(pol_r), .din(din),
    .cause(cause_r), .emask(emask_r), .lmask(lmask_r), .irq_group(irq_group)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, bus_rdata;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  irq_group;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    gpio_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_group(irq_group)
    );

    always #4ns clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected read result actual=%h expected=none", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(8ns * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] outv, dirv, polv, pinv;
        edges(3);
        rst_n = 1'b1;
        edges(1);
        // R1 reset state
        check(pin_oe, 32'h0, "R1 pin_oe");
        check({28'h0, irq_group}, 32'h0, "R1 irq");
        rd(5'h04, 32'hFFFF_FFFF, "R1 dir reset");
        rd(5'h00, 32'h0, "R1 out reset");
        rd(5'h10, 32'h0, "R1 cause reset");
        rd(5'h18, 32'h0, "R1 lmask reset");

        // R4 output drive, R10 map
        outv = 32'h0000_C300; dirv = 32'hFFFF_00FF;
        wr(5'h00, outv);
        wr(5'h04, dirv);
        check(pin_out, outv, "R4 pin_out");
        check(pin_oe, ~dirv, "R4 pin_oe");
        rd(5'h00, outv, "R10 out readback");

        // R2/R3 logical value with inversion, mixed directions
        pinv = 32'h1234_5678; polv = 32'h0000_00FF;
        pin_in = pinv;
        wr(5'h08, polv);
        edges(3);
        rd(5'h0C, ((pinv ^ polv) & dirv) | (outv & ~dirv), "R3 data-in mixed");
        rd(5'h08, polv, "R10 pol readback");
        wr(5'h0C, 32'h0);
        rd(5'h0C, ((pinv ^ polv) & dirv) | (outv & ~dirv), "R3 write ignored");
        wr(5'h08, 32'h0);
        pin_in = '0;
        wr(5'h04, 32'hFFFF_FFFF);
        edges(4);
        wr(5'h10, 32'h0);
        rd(5'h10, 32'h0, "R7 cleared by zeros");

        // R5/R9 level path
        wr(5'h18, 32'h8000_0008);
        pin_in[3] = 1'b1;
        edges(1);
        check({28'h0, irq_group}, 32'h0, "R5 level not yet");
        edges(1);
        check({28'h0, irq_group}, 32'h1, "R5 level due at 2 edges");
        pin_in[3] = 1'b0;
        edges(2);
        check({28'h0, irq_group}, 32'h0, "R5 level not latched");
        pin_in[31] = 1'b1;
        edges(2);
        check({28'h0, irq_group}, 32'h8, "R9 group 3 only");
        pin_in[31] = 1'b0;
        wr(5'h18, 32'h0);
        edges(3);
        rd(5'h10, 32'h8000_0008, "R6 recorded while disabled");
        check({28'h0, irq_group}, 32'h0, "R9 disabled edges quiet");
        wr(5'h10, 32'h0);

        // R6/R7 edge path
        wr(5'h14, 32'h0000_0200);
        pin_in[9] = 1'b1;
        edges(2);
        check({28'h0, irq_group}, 32'h0, "R6 edge not yet");
        edges(1);
        check({28'h0, irq_group}, 32'h2, "R6 edge due at 3 edges");
        pin_in[9] = 1'b0;
        edges(4);
        check({28'h0, irq_group}, 32'h2, "R6 sticky after fall");
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10, 32'h0000_0200, "R7 ones keep");
        wr(5'h10, ~32'h0000_0200);
        rd(5'h10, 32'h0, "R7 ack one line");
        check({28'h0, irq_group}, 32'h0, "R7 irq gone");

        // R2 falling edge via inversion
        wr(5'h14, 32'h0010_0000);
        wr(5'h08, 32'h0010_0000);
        edges(2);
        wr(5'h10, 32'h0);
        check({28'h0, irq_group}, 32'h0, "R2 cleared after inversion");
        pin_in[20] = 1'b1;
        edges(4);
        check({28'h0, irq_group}, 32'h0, "R2 pin rise is logical fall");
        pin_in[20] = 1'b0;
        edges(4);
        check({28'h0, irq_group}, 32'h4, "R2 pin fall caught");
        rd(5'h10, 32'h0010_0000, "R2 flag on fall");
        wr(5'h10, 32'h0);

        // R8 set beats clear on the same edge
        wr(5'h14, 32'h0400_0000);
        pin_in[26] = 1'b1;
        edges(2);
        wr(5'h10, 32'h0);
        rd(5'h10, 32'h0400_0000, "R8 set wins");
        check({28'h0, irq_group}, 32'h8, "R8 irq held");

        edges(3);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10 pending reads actual=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule